// File: doc/BRIEF.md
# Retriggerable Mute Timer One-Shot

This block drives one general-purpose output of a tuning synthesizer. In normal operation that pin mirrors a status bit taken from the serial control word. When the control word arrives with its timer-enable bit set, the pin flips to the opposite level at once. It stays flipped for a fixed number of ticks of a slow external timebase, which defaults to 15 ticks of a 50 Hz tick, or about 300 ms. The radio uses that window to mute audio while it retunes.

The serial interface presents the freshly latched fields and pulses `latchStb` for one clock. Each accepted latch with the enable set adds a full period to the time left, so quick retunes keep the mute running. A later latch with the enable clear does not shorten a pulse that is already running. After reset, the counter first runs through one complete period as a power-up window. During that window the pin is held low and latch events are ignored.

Top module: `muteTimer`

## Requirements
- R1: Reset starts a power-up window. It ends on the first clock after the counter has consumed PERIOD ticks. For the whole window `bitOut` is 0 and latch events do not start a pulse.
- R2: Outside the power-up window, a latch with `enBit`=1 and `outMode`=2'b00 while the timer is idle makes `bitOut` equal to the inverse of `statBit` from the next clock on. No tick is needed for this.
- R3: A pulse started from idle ends exactly when PERIOD ticks have been counted. `bitOut` returns to `statBit` on the clock after the last of those ticks.
- R4: A latch with `enBit`=0 during a pulse neither shortens nor lengthens it.
- R5: A latch with `enBit`=1 and `outMode`=2'b00 during a pulse adds PERIOD ticks to the ticks remaining.
- R6: While `outMode` is not 2'b00, a latch does not start or extend a pulse, and `bitOut` equals `statBit`.
- R7: When the timer is idle and the power-up window is over, `bitOut` equals `statBit`.
- R8: The remaining count saturates at 2^CNT_W-1 instead of wrapping.
- R9: A tick in the same clock as a latch that starts a pulse from idle is not counted. A tick in the same clock as an extending latch is counted, along with the added PERIOD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| latchStb | input | 1 | One-clock pulse marking a newly latched control word |
| enBit | input | 1 | Latched timer-enable field |
| statBit | input | 1 | Latched status field driven to the pin |
| outMode | input | 2 | Latched output-mode field; 2'b00 selects normal operation |
| tick | input | 1 | One-clock timebase tick |
| bitOut | output | 1 | Pin level |

## Verification
The assertions check the count on every clock:
- a latch from idle loads exactly PERIOD;
- a retrigger adds PERIOD, minus a tick that arrives in the same clock, and clamps at the maximum;
- a tick alone decrements the count;
- the count holds when nothing happens.

They also check the pin level throughout the power-up window and whenever a test mode is selected. Some properties span a whole pulse and cannot be checked clock by clock. Only the bench scenarios show them: exact pulse length, retriggers at every offset within a pulse, and a late disable that leaves the pulse untouched.

// File: rtl/muteTimerPkg.sv
package muteTimerPkg;
  typedef struct packed {
    logic load;
    logic extend;
    logic dec;
  } cntCmd_t;
endpackage

// File: rtl/muteCount.sv
module muteCount
  import muteTimerPkg::*;
#(
  parameter int PERIOD = 15,
  parameter int CNT_W  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCmd_t          cmd,
  output logic [CNT_W-1:0] countQ,
  output logic             busy
);
  localparam logic [CNT_W:0]   PER_EXT = (CNT_W+1)'(PERIOD);
  localparam logic [CNT_W:0]   MAX_EXT = (CNT_W+1)'((1 << CNT_W) - 1);
  localparam logic [CNT_W-1:0] PER_CNT = CNT_W'(PERIOD);

  logic [CNT_W:0]   sumExt;
  logic [CNT_W-1:0] countD;

  // Extension adds a period to what is left after this clock's tick.
  always_comb begin
    sumExt = {1'b0, countQ} - (CNT_W+1)'(cmd.dec) + PER_EXT;
    if (sumExt > MAX_EXT) sumExt = MAX_EXT;
  end

  always_comb begin
    countD = countQ;
    if (cmd.load)        countD = PER_CNT;
    else if (cmd.extend) countD = sumExt[CNT_W-1:0];
    else if (cmd.dec)    countD = countQ - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) countQ <= PER_CNT;
    else       countQ <= countD;
  end

  assign busy = (countQ != '0);
endmodule

// File: rtl/muteCtrl.sv
module muteCtrl
  import muteTimerPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       latchStb,
  input  logic       enBit,
  input  logic       statBit,
  input  logic [1:0] outMode,
  input  logic       tick,
  input  logic       busy,
  output cntCmd_t    cmd,
  output logic       powerUp,
  output logic       bitOut
);
  logic normalMode;
  logic trig;

  assign normalMode = (outMode == 2'b00);
  assign trig       = latchStb & enBit & normalMode & ~powerUp;

  always_comb begin
    cmd.load   = trig & ~busy;
    cmd.extend = trig & busy;
    cmd.dec    = tick & busy & ~cmd.load;
  end

  // The power-up window closes once the first period has run out.
  always_ff @(posedge clk) begin
    if (!rstN) powerUp <= 1'b1;
    else       powerUp <= powerUp & busy;
  end

  always_comb begin
    if (powerUp)                 bitOut = 1'b0;
    else if (normalMode && busy) bitOut = ~statBit;
    else                         bitOut = statBit;
  end
endmodule

// File: rtl/muteTimer.sv
module muteTimer
  import muteTimerPkg::*;
#(
  parameter int PERIOD = 15,
  parameter int CNT_W  = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       latchStb,
  input  logic       enBit,
  input  logic       statBit,
  input  logic [1:0] outMode,
  input  logic       tick,
  output logic       bitOut
);
  cntCmd_t          cmd;
  logic [CNT_W-1:0] countQ;
  logic             busy;
  logic             powerUp;

  muteCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .latchStb(latchStb), .enBit(enBit),
    .statBit(statBit), .outMode(outMode), .tick(tick), .busy(busy),
    .cmd(cmd), .powerUp(powerUp), .bitOut(bitOut)
  );

  muteCount #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rstN(rstN), .cmd(cmd), .countQ(countQ), .busy(busy)
  );
endmodule

// File: rtl/muteTimerChecker.sv
module muteTimerChecker #(
  parameter int PERIOD = 15,
  parameter int CNT_W  = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             latchStb,
  input logic             enBit,
  input logic             statBit,
  input logic [1:0]       outMode,
  input logic             tick,
  input logic             bitOut,
  input logic [CNT_W-1:0] countQ,
  input logic             powerUp
);
  localparam int MAXV = (1 << CNT_W) - 1;

  logic accept;
  int   extSum;
  assign accept = latchStb && enBit && (outMode == 2'b00) && !powerUp;
  assign extSum = int'(countQ) + PERIOD - int'(tick);

  AST_PWRUP_LOW: assert property (@(posedge clk) disable iff (!rstN)
    powerUp |-> !bitOut); // R1
  AST_FRESH_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (accept && countQ == '0) |=> countQ == CNT_W'(PERIOD)); // R2
  AST_EXTEND_ADD: assert property (@(posedge clk) disable iff (!rstN)
    (accept && countQ != '0 && extSum <= MAXV) |=> int'(countQ) == $past(extSum)); // R5
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (accept && countQ != '0 && extSum > MAXV) |=> int'(countQ) == MAXV); // R8
  AST_TICK_DEC: assert property (@(posedge clk) disable iff (!rstN)
    (!accept && tick && countQ != '0) |=> countQ == $past(countQ) - 1'b1); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!accept && !tick) |=> $stable(countQ)); // R4
  AST_TEST_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (outMode != 2'b00 && !powerUp) |-> bitOut == statBit); // R6
  AST_IDLE_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == '0 && !powerUp) |-> bitOut == statBit); // R7
endmodule

bind muteTimer muteTimerChecker #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .latchStb(latchStb), .enBit(enBit),
  .statBit(statBit), .outMode(outMode), .tick(tick), .bitOut(bitOut),
  .countQ(countQ), .powerUp(powerUp)
);

// File: tb/muteTimer_bench.sv
module muteTimer_bench;
  localparam int P    = 3;
  localparam int W    = 3;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic latchStb = 1'b0, enBit = 1'b0, statBit = 1'b0, tick = 1'b0;
  logic [1:0] outMode = 2'b00;
  logic bitOut;

  int total = 0;
  int bad = 0;
  int mRem;
  bit mPow;
  bit done = 0;

  always #4 clk = ~clk;

  muteTimer #(.PERIOD(P), .CNT_W(W)) u_muteTimer (
    .clk(clk), .rstN(rstN), .latchStb(latchStb), .enBit(enBit),
    .statBit(statBit), .outMode(outMode), .tick(tick), .bitOut(bitOut)
  );

  task automatic check(input string tag, input bit exp);
    total++;
    if (bitOut !== exp) begin
      bad++;
      $display("FAIL %s: bitOut=%b expected=%b at %0t", tag, bitOut, exp, $time);
    end
  endtask

  function automatic bit expOut();
    if (mPow) return 1'b0;
    if (outMode == 2'b00 && mRem != 0) return ~statBit;
    return statBit;
  endfunction

  // One clock of stimulus, the model update for that edge, then a check.
  task automatic step(input string tag, input bit lat, input bit en, input bit st,
                      input bit [1:0] md, input bit tk);
    bit trig;
    @(negedge clk);
    latchStb = lat; enBit = en; statBit = st; outMode = md; tick = tk;
    trig = lat && en && md == 2'b00 && !mPow;
    mPow = mPow && (mRem != 0);
    if (trig && mRem == 0) mRem = P;
    else if (trig) begin
      mRem = mRem - int'(tk) + P;
      if (mRem > MAXV) mRem = MAXV;
    end else if (tk && mRem != 0) mRem--;
    @(negedge clk);
    latchStb = 1'b0; tick = 1'b0;
    check(tag, expOut());
  endtask

  task automatic runOut(input string tag);
    while (mRem != 0 || mPow) step(tag, 0, enBit, statBit, outMode, 1);
    step(tag, 0, enBit, statBit, outMode, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mRem = P; mPow = 1;
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0);
    rstN = 1'b1;
    // R1: latch during power-up window is ignored
    step("R1 ignore", 1, 1, 1, 2'b00, 0);
    runOut("R1 window");
    // R7: idle follows status
    for (int v = 0; v < 4; v++) step("R7 follow", 1, 0, v[0], 2'b00, 0);
    // R2/R3/R5 sweep over status and retrigger offset
    for (int st = 0; st < 2; st++) begin
      for (int k = 0; k <= P; k++) begin
        step("R2 start", 1, 1, st[0], 2'b00, 0);
        for (int t = 0; t < k; t++) step("R3 count", 0, 1, st[0], 2'b00, 1);
        step("R5 retrig", 1, 1, st[0], 2'b00, 0);
        runOut("R3 end");
      end
    end
    // R4: disable latched mid-pulse keeps the pulse
    step("R4 start", 1, 1, 1, 2'b00, 0);
    step("R4 tick", 0, 1, 1, 2'b00, 1);
    step("R4 clear", 1, 0, 1, 2'b00, 0);
    runOut("R4 finish");
    // R6: test modes neither trigger nor invert
    for (int md = 1; md < 4; md++) begin
      step("R6 no trig", 1, 1, 1, md[1:0], 0);
      step("R6 no trig", 1, 1, 0, md[1:0], 1);
    end
    step("R6 start", 1, 1, 0, 2'b00, 0);
    step("R6 mode", 1, 1, 0, 2'b10, 0);
    step("R6 back", 0, 1, 0, 2'b00, 1);
    runOut("R6 end");
    // R8: stacked retriggers saturate
    for (int i = 0; i < 5; i++) step("R8 stack", 1, 1, 1, 2'b00, 0);
    runOut("R8 drain");
    // R9: tick coinciding with start and with extend
    step("R9 start+tick", 1, 1, 0, 2'b00, 1);
    step("R9 ext+tick", 1, 1, 0, 2'b00, 1);
    runOut("R9 drain");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule